// File: doc/BRIEF.md
# Reconfigurable 4096-Bit Memory Block

This block holds 4096 bits of storage that can work as a two-port random-access memory or as a synchronous first-in-first-out queue. A configuration code chooses the shape of the array: one of four width and depth splits, from one bit wide and 4096 deep up to eight bits wide and 512 deep. A second code chooses how the array is used. The surrounding fabric drives every input. Every output drives a plain signal back into that fabric.

In the RAM modes, two ports share the array. Each port has its own address, write enable, write data and read data. Writes always happen on the clock edge. Reads are either combinational (asynchronous mode) or registered (synchronous mode). In FIFO mode, a push/pop interface uses the same array as a circular buffer and reports registered full and empty flags. The configuration codes are sampled only while reset is held low. The block takes its clock from one of four global clock lines, and a parameter fixes which line is used.

Top module: `cfg_mem_block`

## Requirements
- R1: The ratio code sets the organisation as follows: 0 gives 4096x1, 1 gives 2048x2, 2 gives 1024x4 and 3 gives 512x8. The address width in use is 12 minus the code. Address bits above that width are ignored, so an address with extra upper bits set reaches the same location.
- R2: Read-data bits above the configured width always read as zero. Write-data bits above the configured width have no effect on the stored data.
- R3: In mode code 1 (synchronous RAM), read data is registered. It is valid one clock edge after the address is presented. When a location is written on the same edge, the read returns the value held before that write.
- R4: In mode code 0 (asynchronous RAM), read data follows the address with no clock edge. Writes still take effect on the clock edge.
- R5: The two ports write independently. Writes to different addresses on the same edge both take effect, even when those addresses share one physical storage word.
- R6: When both ports write the same address on the same edge, the port A data is stored.
- R7: In mode codes 2 and 3 (FIFO), entries come out in the order they were pushed. The pop data register loads the head entry on each accepted pop.
- R8: A push while full is ignored. A pop while empty is ignored and leaves the pop data unchanged.
- R9: A push and a pop that are both accepted on the same edge leave the occupancy unchanged.
- R10: The full flag is registered and rises after the push that brings the occupancy to the configured depth (4096 shifted right by the ratio code). The empty flag is registered and is high whenever the occupancy is zero. In the RAM modes, empty reads 1 and full reads 0.
- R11: The ratio and mode codes are captured only while `rst_n` is low, and reset uses the synchronous style. Reset clears the FIFO pointers, the occupancy, the flags and the read-data registers. A change to either code while out of reset has no effect.
- R12: The parameter `CLK_SEL` chooses which line of `gclk` clocks the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 4 | Global clock lines; the line at index CLK_SEL is used |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_ratio | input | 2 | Width/depth split code |
| cfg_mode | input | 2 | 0 async RAM, 1 sync RAM, 2 or 3 FIFO |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 12 | Port A address |
| a_wdata | input | 8 | Port A write data, low bits used |
| a_rdata | output | 8 | Port A read data |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 12 | Port B address |
| b_wdata | input | 8 | Port B write data, low bits used |
| b_rdata | output | 8 | Port B read data |
| f_push | input | 1 | FIFO push request |
| f_wdata | input | 8 | FIFO push data |
| f_pop | input | 1 | FIFO pop request |
| f_rdata | output | 8 | FIFO pop data, registered |
| f_full | output | 1 | FIFO full flag |
| f_empty | output | 1 | FIFO empty flag |

## Verification
The assertions check on every cycle that the FIFO flags are never both high, that an ignored push or pop leaves the flags and the pop data unchanged, that an accepted push clears empty, that the RAM modes hold the flags at their idle values, and that the captured mode stays fixed outside reset. Some properties cannot be checked cycle by cycle in this way. These are the data results: aliasing between organisations, read-before-write ordering, the port A collision priority, lane merging within a shared word, and FIFO ordering across the whole depth. Only the bench sweeps show them, because they compare each read value against a pattern computed from the address.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
   localparam int CMB_MAX_DW   = 8;
   localparam int CMB_WORDS    = 512;
   localparam int CMB_CLKLINES = 4;

   typedef enum logic [1:0] {
      MODE_ARAM = 2'd0,
      MODE_SRAM = 2'd1,
      MODE_FIFO = 2'd2,
      MODE_FIFX = 2'd3
   } cmb_mode_e;

   function automatic logic is_fifo(input logic [1:0] m);
      return m[1];
   endfunction
endpackage

// File: rtl/cmb_lane_map.sv
module cmb_lane_map #(
   parameter int MAX_DW = 8,
   parameter int WORDS  = 512,
   parameter int RW     = 2,
   localparam int LG_DW = $clog2(MAX_DW),
   localparam int WIW   = $clog2(WORDS),
   localparam int AW    = WIW + LG_DW
) (
   input  logic [RW-1:0]     ratio,
   input  logic [AW-1:0]     addr,
   input  logic [MAX_DW-1:0] wdata,
   input  logic [MAX_DW-1:0] rword,
   output logic [WIW-1:0]    word_idx,
   output logic [MAX_DW-1:0] lane_mask,
   output logic [MAX_DW-1:0] wdata_pos,
   output logic [MAX_DW-1:0] rdata
);
   always_comb begin
      int sh;
      int wdt;
      int off;
      logic [AW-1:0]     wa;
      logic [MAX_DW-1:0] low;
      sh  = LG_DW - int'(ratio);
      wdt = 1 << int'(ratio);
      wa  = addr >> sh;
      off = (int'(addr) & ((1 << sh) - 1)) * wdt;
      low = '0;
      for (int i = 0; i < MAX_DW; i++) begin
         if (i < wdt) low[i] = 1'b1;
      end
      word_idx  = wa[WIW-1:0];
      lane_mask = low << off;
      wdata_pos = (wdata & low) << off;
      rdata     = (rword >> off) & low;
   end
endmodule

// File: rtl/cmb_store.sv
module cmb_store #(
   parameter int MAX_DW = 8,
   parameter int WORDS  = 512,
   localparam int WIW   = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              a_we,
   input  logic [WIW-1:0]    a_idx,
   input  logic [MAX_DW-1:0] a_mask,
   input  logic [MAX_DW-1:0] a_data,
   input  logic              b_we,
   input  logic [WIW-1:0]    b_idx,
   input  logic [MAX_DW-1:0] b_mask,
   input  logic [MAX_DW-1:0] b_data,
   input  logic [WIW-1:0]    ra_idx,
   input  logic [WIW-1:0]    rb_idx,
   output logic [MAX_DW-1:0] ra_word,
   output logic [MAX_DW-1:0] rb_word
);
   logic [MAX_DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (a_we && b_we && (a_idx == b_idx)) begin
         mem[a_idx] <= (mem[a_idx] & ~(a_mask | b_mask))
                     | (a_data & a_mask)
                     | (b_data & b_mask & ~a_mask);
      end else begin
         if (a_we) mem[a_idx] <= (mem[a_idx] & ~a_mask) | (a_data & a_mask);
         if (b_we) mem[b_idx] <= (mem[b_idx] & ~b_mask) | (b_data & b_mask);
      end
   end

   assign ra_word = mem[ra_idx];
   assign rb_word = mem[rb_idx];
endmodule

// File: rtl/cmb_fifo_ctrl.sv
module cmb_fifo_ctrl #(
   parameter int DEPTH_MAX = 4096,
   parameter int RW        = 2,
   localparam int PW       = $clog2(DEPTH_MAX),
   localparam int CW       = $clog2(DEPTH_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [RW-1:0] ratio,
   input  logic          push,
   input  logic          pop,
   output logic [PW-1:0] wr_ptr,
   output logic [PW-1:0] rd_ptr,
   output logic          push_ok,
   output logic          pop_ok,
   output logic          full,
   output logic          empty
);
   logic [CW-1:0] count_q, count_n;
   logic [PW-1:0] wr_n, rd_n;
   logic [CW-1:0] depth;

   assign depth   = CW'(DEPTH_MAX >> int'(ratio));
   assign push_ok = en && push && !full;
   assign pop_ok  = en && pop && !empty;

   always_comb begin
      logic [PW-1:0] wrap;
      wrap    = PW'(depth - 1'b1);
      wr_n    = push_ok ? ((wr_ptr + 1'b1) & wrap) : wr_ptr;
      rd_n    = pop_ok  ? ((rd_ptr + 1'b1) & wrap) : rd_ptr;
      count_n = count_q;
      if (push_ok && !pop_ok) count_n = count_q + 1'b1;
      if (pop_ok && !push_ok) count_n = count_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
         full    <= 1'b0;
         empty   <= 1'b1;
      end else begin
         wr_ptr  <= wr_n;
         rd_ptr  <= rd_n;
         count_q <= count_n;
         full    <= en && (count_n == depth);
         empty   <= !en || (count_n == '0);
      end
   end
endmodule

// File: rtl/cfg_mem_block.sv
module cfg_mem_block
   import cmb_pkg::*;
#(
   parameter int MAX_DW    = CMB_MAX_DW,
   parameter int WORDS     = CMB_WORDS,
   parameter int CLK_LINES = CMB_CLKLINES,
   parameter int CLK_SEL   = 0,
   localparam int LG_DW    = $clog2(MAX_DW),
   localparam int RW       = $clog2(LG_DW + 1),
   localparam int WIW      = $clog2(WORDS),
   localparam int AW       = WIW + LG_DW,
   localparam int NP       = 2
) (
   input  logic [CLK_LINES-1:0] gclk,
   input  logic                 rst_n,
   input  logic [RW-1:0]        cfg_ratio,
   input  logic [1:0]           cfg_mode,
   input  logic                 a_we,
   input  logic [AW-1:0]        a_addr,
   input  logic [MAX_DW-1:0]    a_wdata,
   output logic [MAX_DW-1:0]    a_rdata,
   input  logic                 b_we,
   input  logic [AW-1:0]        b_addr,
   input  logic [MAX_DW-1:0]    b_wdata,
   output logic [MAX_DW-1:0]    b_rdata,
   input  logic                 f_push,
   input  logic [MAX_DW-1:0]    f_wdata,
   input  logic                 f_pop,
   output logic [MAX_DW-1:0]    f_rdata,
   output logic                 f_full,
   output logic                 f_empty
);
   // elaboration-time parameter checks
   if (CLK_SEL < 0 || CLK_SEL >= CLK_LINES) begin : g_bad_sel
      $error("CLK_SEL out of range");
   end
   if ((1 << LG_DW) != MAX_DW) begin : g_bad_dw
      $error("MAX_DW must be a power of two");
   end
   if ((1 << WIW) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two");
   end

   logic core_clk;
   if (CLK_LINES == 1) begin : g_clk_single
      assign core_clk = gclk[0];
   end else begin : g_clk_pick
      assign core_clk = gclk[CLK_SEL];
   end

   // configuration captured while reset is held
   logic [RW-1:0] ratio_q;
   logic [1:0]    mode_q;
   logic          fifo_on;

   always_ff @(posedge core_clk) begin
      if (!rst_n) begin
         ratio_q <= cfg_ratio;
         mode_q  <= cfg_mode;
      end
   end
   assign fifo_on = is_fifo(mode_q);

   // fifo control
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   cmb_fifo_ctrl #(.DEPTH_MAX(WORDS * MAX_DW), .RW(RW)) u_fifo (
      .clk    (core_clk),
      .rst_n  (rst_n),
      .en     (fifo_on),
      .ratio  (ratio_q),
      .push   (f_push),
      .pop    (f_pop),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .push_ok(push_ok),
      .pop_ok (pop_ok),
      .full   (f_full),
      .empty  (f_empty)
   );

   // per-port signals
   logic [NP-1:0]     p_we;
   logic [AW-1:0]     p_addr  [NP];
   logic [MAX_DW-1:0] p_wdata [NP];
   logic [WIW-1:0]    p_idx   [NP];
   logic [MAX_DW-1:0] p_mask  [NP];
   logic [MAX_DW-1:0] p_wpos  [NP];
   logic [MAX_DW-1:0] p_rword [NP];
   logic [MAX_DW-1:0] p_rcomb [NP];
   logic [MAX_DW-1:0] p_rq    [NP];
   logic [MAX_DW-1:0] p_out   [NP];

   // port 0 carries the fifo push path in fifo mode
   assign p_we[0]    = fifo_on ? push_ok : a_we;
   assign p_addr[0]  = fifo_on ? wr_ptr  : a_addr;
   assign p_wdata[0] = fifo_on ? f_wdata : a_wdata;
   assign p_we[1]    = !fifo_on && b_we;
   assign p_addr[1]  = b_addr;
   assign p_wdata[1] = b_wdata;

   for (genvar g = 0; g < NP; g++) begin : g_port
      cmb_lane_map #(.MAX_DW(MAX_DW), .WORDS(WORDS), .RW(RW)) u_map (
         .ratio    (ratio_q),
         .addr     (p_addr[g]),
         .wdata    (p_wdata[g]),
         .rword    (p_rword[g]),
         .word_idx (p_idx[g]),
         .lane_mask(p_mask[g]),
         .wdata_pos(p_wpos[g]),
         .rdata    (p_rcomb[g])
      );

      always_ff @(posedge core_clk) begin
         if (!rst_n)       p_rq[g] <= '0;
         else if (fifo_on) p_rq[g] <= '0;
         else              p_rq[g] <= p_rcomb[g];
      end

      assign p_out[g] = (mode_q == MODE_ARAM) ? p_rcomb[g] : p_rq[g];
   end

   assign a_rdata = p_out[0];
   assign b_rdata = p_out[1];

   // fifo read path
   logic [WIW-1:0]    f_idx;
   logic [MAX_DW-1:0] f_rcomb;
   logic [MAX_DW-1:0] f_mask_unused, f_wpos_unused;
   logic [WIW-1:0]    rb_idx;
   logic [MAX_DW-1:0] rb_word;

   cmb_lane_map #(.MAX_DW(MAX_DW), .WORDS(WORDS), .RW(RW)) u_fmap (
      .ratio    (ratio_q),
      .addr     (rd_ptr),
      .wdata    ('0),
      .rword    (rb_word),
      .word_idx (f_idx),
      .lane_mask(f_mask_unused),
      .wdata_pos(f_wpos_unused),
      .rdata    (f_rcomb)
   );

   assign rb_idx     = fifo_on ? f_idx : p_idx[1];
   assign p_rword[1] = rb_word;

   always_ff @(posedge core_clk) begin
      if (!rst_n)      f_rdata <= '0;
      else if (pop_ok) f_rdata <= f_rcomb;
   end

   cmb_store #(.MAX_DW(MAX_DW), .WORDS(WORDS)) u_store (
      .clk    (core_clk),
      .a_we   (p_we[0]),
      .a_idx  (p_idx[0]),
      .a_mask (p_mask[0]),
      .a_data (p_wpos[0]),
      .b_we   (p_we[1]),
      .b_idx  (p_idx[1]),
      .b_mask (p_mask[1]),
      .b_data (p_wpos[1]),
      .ra_idx (p_idx[0]),
      .rb_idx (rb_idx),
      .ra_word(p_rword[0]),
      .rb_word(rb_word)
   );
endmodule

// File: rtl/cmb_chk.sv
module cmb_chk #(
   parameter int MAX_DW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode_q,
   input logic              f_push,
   input logic              f_pop,
   input logic [MAX_DW-1:0] f_rdata,
   input logic              f_full,
   input logic              f_empty
);
   // R10
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(f_full && f_empty));

   // R8
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] && f_full && f_push && !f_pop) |=> (f_full && $stable(f_rdata)));

   // R8
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] && f_empty && f_pop && !f_push) |=> (f_empty && $stable(f_rdata)));

   // R7
   push_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] && f_push && !f_full) |=> !f_empty);

   // R10
   ram_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[1]) |=> (f_empty && !f_full));

   // R11
   cfg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(mode_q));
endmodule

bind cfg_mem_block cmb_chk #(.MAX_DW(MAX_DW)) u_chk (
   .clk    (core_clk),
   .rst_n  (rst_n),
   .mode_q (mode_q),
   .f_push (f_push),
   .f_pop  (f_pop),
   .f_rdata(f_rdata),
   .f_full (f_full),
   .f_empty(f_empty)
);

// File: tb/cfg_mem_block_bench.sv
module cfg_mem_block_bench;
   logic [3:0]  gclk;
   logic        rst_n;
   logic [1:0]  cfg_ratio, cfg_mode;
   logic        a_we, b_we, f_push, f_pop;
   logic [11:0] a_addr, b_addr;
   logic [7:0]  a_wdata, b_wdata, f_wdata;
   logic [7:0]  a_rdata, b_rdata, f_rdata;
   logic        f_full, f_empty;
   int total = 0;
   int bad   = 0;

   cfg_mem_block u_cfg_mem_block (.*);

   initial gclk = 4'b0;
   always #4 gclk[0] = ~gclk[0];   // 125 MHz on line 0 (R12)

   task automatic tick();
      @(posedge gclk[0]);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int wm(input int r);
      return (1 << (1 << r)) - 1;
   endfunction

   function automatic int pat(input int a, input int r, input int salt);
      return (a * 13 + salt) & wm(r);
   endfunction

   task automatic do_reset(input int r, input int m);
      cfg_ratio = 2'(r); cfg_mode = 2'(m); rst_n = 0;
      a_we = 0; b_we = 0; f_push = 0; f_pop = 0;
      a_addr = 0; b_addr = 0; a_wdata = 0; b_wdata = 0; f_wdata = 0;
      tick(); tick();
      rst_n = 1;
      tick();
   endtask

   // FIFO model
   int mdl [4096];
   int hd, tl, cnt, dep, last;

   task automatic fstep(input bit ps, input bit pp, input int r, input int seq);
      bit pok, qok;
      int d;
      pok = ps && (cnt < dep);
      qok = pp && (cnt > 0);
      d = ((seq * 7 + 1) & 8'hFF) | (~wm(r) & 8'hFF);
      f_push = ps; f_pop = pp; f_wdata = 8'(d);
      if (qok) begin last = mdl[hd]; hd = (hd + 1) % dep; end
      if (pok) begin mdl[tl] = d & wm(r); tl = (tl + 1) % dep; end
      cnt = cnt + int'(pok) - int'(qok);
      tick();
      f_push = 0; f_pop = 0;
      chk(qok ? "R7 pop data" : "R8 pop data held", int'(f_rdata), last);
      chk("R10 full flag", int'(f_full), int'(cnt == dep));
      chk("R10 empty flag", int'(f_empty), int'(cnt == 0));
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge gclk[0]);
      total++; bad++;
      $display("FAIL watchdog act=hang exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int dpt;
      // R11 reset state
      do_reset(3, 1);
      chk("R11 reset a_rdata", int'(a_rdata), 0);
      chk("R10 ram empty", int'(f_empty), 1);
      chk("R10 ram full", int'(f_full), 0);

      // R1 R2 R5 sync sweep over every organisation
      for (int r = 0; r < 4; r++) begin
         do_reset(r, 1);
         dpt = 4096 >> r;
         for (int i = 0; i < dpt / 2; i++) begin
            a_we = 1; b_we = 1;
            a_addr = 12'(2 * i);     a_wdata = 8'(pat(2 * i, r, 3) | (~wm(r) & 8'hFF));
            b_addr = 12'(2 * i + 1); b_wdata = 8'(pat(2 * i + 1, r, 3) | (~wm(r) & 8'hFF));
            tick();
         end
         a_we = 0; b_we = 0;
         for (int i = 0; i < dpt; i++) begin
            a_addr = 12'(i | ((r > 0) ? (5 << (12 - r)) : 0));  // R1 upper bits alias
            b_addr = 12'(dpt - 1 - i);
            tick();
            chk("R1 R2 R5 port A read", int'(a_rdata), pat(i, r, 3));
            chk("R2 R5 port B read", int'(b_rdata), pat(dpt - 1 - i, r, 3));
         end
      end

      // R3 read-before-write, R6 collision, R11 config change ignored
      do_reset(3, 1);
      a_we = 1; a_addr = 5; a_wdata = 8'h11; tick();
      a_wdata = 8'h22; tick();
      chk("R3 old data on same-edge write", int'(a_rdata), 8'h11);
      a_we = 0; tick();
      chk("R3 new data next edge", int'(a_rdata), 8'h22);
      a_we = 1; b_we = 1; a_addr = 7; b_addr = 7; a_wdata = 8'h44; b_wdata = 8'h33; tick();
      a_we = 0; b_we = 0; b_addr = 7; tick();
      chk("R6 port A wins", int'(b_rdata), 8'h44);
      cfg_ratio = 0; cfg_mode = 2; a_addr = 5; tick(); tick();
      chk("R11 ratio change ignored", int'(a_rdata), 8'h22);
      chk("R11 mode change ignored", int'(f_empty), 1);

      // R5 lanes sharing a word in x1 mode
      do_reset(0, 1);
      a_we = 1; b_we = 1; a_addr = 8; b_addr = 9; a_wdata = 1; b_wdata = 1; tick();
      a_addr = 10; b_addr = 11; a_wdata = 0; b_wdata = 0; tick();
      a_we = 0; b_we = 0; a_addr = 8; b_addr = 9; tick();
      chk("R5 lane merge A", int'(a_rdata), 1);
      chk("R5 lane merge B", int'(b_rdata), 1);

      // R4 asynchronous reads
      do_reset(2, 0);
      for (int i = 0; i < 16; i++) begin
         a_we = 1; a_addr = 12'(i); a_wdata = 8'(pat(i, 2, 9)); tick();
      end
      a_we = 0;
      for (int i = 0; i < 16; i++) begin
         a_addr = 12'(i); b_addr = 12'(15 - i);
         #2;
         chk("R4 async A", int'(a_rdata), pat(i, 2, 9));
         chk("R4 async B", int'(b_rdata), pat(15 - i, 2, 9));
      end
      tick();

      // R7 R8 R9 R10 FIFO in every organisation
      for (int r = 0; r < 4; r++) begin
         do_reset(r, 2 + (r & 1));
         dep = 4096 >> r; hd = 0; tl = 0; cnt = 0; last = 0;
         chk("R10 fifo reset empty", int'(f_empty), 1);
         chk("R10 fifo reset full", int'(f_full), 0);
         fstep(0, 1, r, 0);                        // R8 pop when empty
         fstep(1, 1, r, 1);                        // push only accepted
         fstep(0, 1, r, 2);
         for (int i = 0; i < dep; i++) fstep(1, 0, r, i + 10);
         fstep(1, 0, r, 99);                       // R8 push when full
         fstep(1, 1, r, 98);                       // pop only accepted
         fstep(1, 1, r, 97);                       // R9 both accepted
         chk("R9 occupancy kept", cnt, dep - 1);
         for (int i = 0; i < dep - 1; i++) fstep(0, 1, r, 0);
         fstep(0, 1, r, 0);                        // R8 pop when empty
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule